// File: doc/BRIEF.md
# UART Interrupt Source and Mask Controller

This block turns the status conditions of a serial-controlled UART into four readable status bits and one active-low interrupt request. The four sources are: the parity bit of the word at the head of the receive FIFO, receive data waiting, a shared line-condition bit, and transmit buffer empty. Each source has its own mask input. A source can pull the interrupt low only while its mask is 1.

The shared line-condition bit changes meaning with the power mode. In shutdown it reports activity on the RX line: an edge detector sits behind a synchronizer on that line, and any edge sets a latch. In run mode the same bit reports a framing error. That error is set by a stop-bit sample of 0 and cleared by the next good stop-bit sample. The transmit source is split into two parts. The status bit is the live empty level, which software can poll. The interrupt comes from a separate latch. That latch is set when the buffer becomes empty and cleared by the chip-select rising edge that ends a data read.

The UART datapath, the FIFO storage and the command decoder sit outside this block and drive its inputs.

Top module: `uart_irq_ctrl`

## Requirements
- R1: `st_par` is 1 in the same cycle exactly when `parity_en`, `fifo_not_empty` and `head_parity` are all 1. Otherwise it is 0.
- R2: `st_rx` equals `fifo_not_empty` in the same cycle.
- R3: While `st_rx` and `mask_rx` are both 1, `irq_n` is 0.
- R4: While `shutdown` is 1, `st_ra_fe` shows the RX-activity latch. The latch is set on the third rising clock edge after `rx_line` changes. The latch is cleared on any clock edge where `shutdown` is 0, so re-entering shutdown starts with it at 0.
- R5: While `shutdown` is 0, `st_ra_fe` shows the framing-error latch. A `stop_strobe` with `stop_bit` = 0 sets the latch on that edge. A `stop_strobe` with `stop_bit` = 1 clears it. With no strobe, the latch holds its value.
- R6: The transmit interrupt latch is set on the edge after `tx_empty` goes from 0 to 1, provided `mask_tx` is 1 at that edge. A rise that happens while `mask_tx` is 0 is not remembered.
- R7: A `rd_cs_rise` pulse clears the transmit interrupt latch on that edge. If a new empty rise arrives in the same cycle, the latch stays set.
- R8: `st_tx` follows `tx_empty` in the same cycle, whatever the state of the transmit latch.
- R9: `irq_n` is 0 exactly when at least one of the following holds: `st_par` and `mask_par`, `st_rx` and `mask_rx`, `st_ra_fe` and `mask_ra`, or the transmit latch and `mask_tx`. Otherwise `irq_n` is 1.
- R10: Asynchronous reset clears all latches. With no live source active, `irq_n` is then 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mask_par | input | 1 | Enables the parity source onto the interrupt |
| mask_rx | input | 1 | Enables the receive-available source |
| mask_ra | input | 1 | Enables the shared line-condition source |
| mask_tx | input | 1 | Enables the transmit-empty source |
| fifo_not_empty | input | 1 | Receive FIFO holds unread data |
| head_parity | input | 1 | Received parity bit of the word at the FIFO head |
| parity_en | input | 1 | Parity is enabled |
| shutdown | input | 1 | Device is in shutdown mode |
| rx_line | input | 1 | Raw asynchronous RX line |
| stop_strobe | input | 1 | One-cycle pulse when the first stop bit is sampled |
| stop_bit | input | 1 | Value sampled at the stop-bit position |
| tx_empty | input | 1 | Transmit buffer empty level |
| rd_cs_rise | input | 1 | One-cycle pulse at the chip-select rising edge that ends a data read |
| st_par | output | 1 | Parity status |
| st_rx | output | 1 | Receive data available status |
| st_ra_fe | output | 1 | RX activity (shutdown) or framing error (run) |
| st_tx | output | 1 | Live transmit buffer empty status |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Two functions can fall in the same cycle: a new transmit-empty rise, which sets the interrupt latch, and the read-ending chip-select pulse, which clears it. The bench first sets the latch and drops the empty level. In one cycle it then raises `tx_empty` and pulses `rd_cs_rise` together. With only the transmit source unmasked, it checks that `irq_n` stays low after the edge. A second meeting point is leaving and re-entering shutdown: the bench checks that an RX edge seen in the earlier shutdown interval does not carry over into the next one.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef struct packed {
        logic ra;   // RX activity seen during shutdown
        logic fe;   // framing error of last stop sample
        logic txi;  // latched transmit-empty interrupt
    } irq_lat_t;

endpackage

// File: rtl/irq_rx_edge.sv
module irq_rx_edge #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_async,
    output logic edge_seen
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = rx_async;
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_pipe
        always_comb pipe_d[i] = pipe_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {DEPTH{IDLE}};
        else        pipe_q <= pipe_d;
    end

    assign edge_seen = pipe_q[DEPTH-1] ^ pipe_q[DEPTH-2];

endmodule

// File: rtl/irq_tx_event.sv
module irq_tx_event (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb prev_d = level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = level & ~prev_q;

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mask_par,
    input  logic mask_rx,
    input  logic mask_ra,
    input  logic mask_tx,
    input  logic fifo_not_empty,
    input  logic head_parity,
    input  logic parity_en,
    input  logic shutdown,
    input  logic rx_line,
    input  logic stop_strobe,
    input  logic stop_bit,
    input  logic tx_empty,
    input  logic rd_cs_rise,
    output logic st_par,
    output logic st_rx,
    output logic st_ra_fe,
    output logic st_tx,
    output logic irq_n
);
    irq_lat_t lat_d, lat_q;
    logic     rx_edge;
    logic     tx_rise;

    irq_rx_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_rx_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_async (rx_line),
        .edge_seen(rx_edge)
    );

    irq_tx_event u_tx_event (
        .clk  (clk),
        .rst_n(rst_n),
        .level(tx_empty),
        .rise (tx_rise)
    );

    always_comb begin
        lat_d = lat_q;
        // RX activity: held clear outside shutdown
        if (!shutdown)    lat_d.ra = 1'b0;
        else if (rx_edge) lat_d.ra = 1'b1;
        // framing error follows each stop-bit sample
        if (stop_strobe)  lat_d.fe = ~stop_bit;
        // transmit interrupt: a new event beats the clearing read
        if (tx_rise && mask_tx) lat_d.txi = 1'b1;
        else if (rd_cs_rise)    lat_d.txi = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign st_par   = parity_en & fifo_not_empty & head_parity;
    assign st_rx    = fifo_not_empty;
    assign st_ra_fe = shutdown ? lat_q.ra : lat_q.fe;
    assign st_tx    = tx_empty;
    assign irq_n    = ~((st_par & mask_par) | (st_rx & mask_rx) |
                        (st_ra_fe & mask_ra) | (lat_q.txi & mask_tx));

    AST_PAR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !parity_en |-> !st_par);                                       // R1
    AST_RX_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_not_empty && mask_rx) |-> !irq_n);                       // R3
    AST_RA_RUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !shutdown |=> !lat_q.ra);                                      // R4
    AST_FE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_strobe && !stop_bit) |=> lat_q.fe);                      // R5
    AST_FE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_strobe |=> $stable(lat_q.fe));                           // R5
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q.txi && !rd_cs_rise) |=> lat_q.txi);                     // R7
    AST_TX_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_rise && mask_tx && rd_cs_rise) |=> lat_q.txi);             // R7
    AST_TX_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        st_tx == tx_empty);                                            // R8

endmodule

// File: tb/sim_uart_irq_ctrl.sv
`timescale 1ns/1ps
module sim_uart_irq_ctrl;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mask_par = 0, mask_rx = 0, mask_ra = 0, mask_tx = 0;
    logic fifo_not_empty = 0, head_parity = 0, parity_en = 0, shutdown = 0;
    logic rx_line = 1, stop_strobe = 0, stop_bit = 1, tx_empty = 0, rd_cs_rise = 0;
    logic st_par, st_rx, st_ra_fe, st_tx, irq_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .mask_par(mask_par), .mask_rx(mask_rx), .mask_ra(mask_ra), .mask_tx(mask_tx),
        .fifo_not_empty(fifo_not_empty), .head_parity(head_parity),
        .parity_en(parity_en), .shutdown(shutdown), .rx_line(rx_line),
        .stop_strobe(stop_strobe), .stop_bit(stop_bit), .tx_empty(tx_empty),
        .rd_cs_rise(rd_cs_rise),
        .st_par(st_par), .st_rx(st_rx), .st_ra_fe(st_ra_fe), .st_tx(st_tx),
        .irq_n(irq_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic masks(input logic p, input logic r, input logic a, input logic t);
        mask_par = p; mask_rx = r; mask_ra = a; mask_tx = t;
    endtask

    task automatic t_reset();
        masks(1, 1, 1, 1);
        step(1);
        check("R10 irq_n in reset", irq_n, 1'b1);
        check("R10 st_ra_fe in reset", st_ra_fe, 1'b0);
        rst_n = 1'b1;
        step(2);
        check("R10 irq_n after reset", irq_n, 1'b1);
        masks(0, 0, 0, 0);
    endtask

    task automatic t_parity();
        fifo_not_empty = 1; head_parity = 1; parity_en = 0; #1;
        check("R1 parity disabled", st_par, 1'b0);
        parity_en = 1; #1;
        check("R1 parity bit 1", st_par, 1'b1);
        masks(0, 0, 0, 0); #1;
        check("R9 parity masked", irq_n, 1'b1);
        mask_par = 1; #1;
        check("R9 parity unmasked", irq_n, 1'b0);
        head_parity = 0; #1;
        check("R1 parity bit 0", st_par, 1'b0);
        head_parity = 1; fifo_not_empty = 0; #1;
        check("R1 fifo empty", st_par, 1'b0);
        masks(0, 0, 0, 0); parity_en = 0; head_parity = 0;
        step(1);
    endtask

    task automatic t_rx_avail();
        fifo_not_empty = 1; #1;
        check("R2 st_rx set", st_rx, 1'b1);
        check("R3 masked off", irq_n, 1'b1);
        mask_rx = 1; #1;
        check("R3 irq with data", irq_n, 1'b0);
        fifo_not_empty = 0; #1;
        check("R2 st_rx cleared", st_rx, 1'b0);
        check("R3 irq released", irq_n, 1'b1);
        mask_rx = 0;
        step(1);
    endtask

    task automatic t_shutdown_activity();
        mask_ra = 1;
        shutdown = 1;
        step(3);
        check("R4 clear on entry", st_ra_fe, 1'b0);
        rx_line = 0;
        step(2);
        check("R4 not yet after two edges", st_ra_fe, 1'b0);
        step(1);
        check("R4 set on third edge", st_ra_fe, 1'b1);
        check("R9 RA irq", irq_n, 1'b0);
        mask_ra = 0; #1;
        check("R9 RA masked", irq_n, 1'b1);
        rx_line = 1;
        step(4);
        shutdown = 0;
        step(2);
        shutdown = 1; #1;
        check("R4 cleared across exit", st_ra_fe, 1'b0);
        shutdown = 0;
        step(1);
    endtask

    task automatic t_framing();
        stop_strobe = 1; stop_bit = 0;
        step(1);
        stop_strobe = 0; stop_bit = 1;
        check("R5 FE set", st_ra_fe, 1'b1);
        step(3);
        check("R5 FE holds", st_ra_fe, 1'b1);
        fifo_not_empty = 1; #1;
        check("R5 FE independent of FIFO", st_ra_fe, 1'b1);
        fifo_not_empty = 0;
        stop_strobe = 1; stop_bit = 1;
        step(1);
        stop_strobe = 0;
        check("R5 FE cleared", st_ra_fe, 1'b0);
    endtask

    task automatic t_tx();
        masks(0, 0, 0, 1);
        tx_empty = 1; #1;
        check("R8 st_tx live", st_tx, 1'b1);
        check("R6 not before edge", irq_n, 1'b1);
        step(1);
        check("R6 latch set", irq_n, 1'b0);
        rd_cs_rise = 1;
        step(1);
        rd_cs_rise = 0;
        check("R7 read clears", irq_n, 1'b1);
        check("R8 st_tx after clear", st_tx, 1'b1);
        tx_empty = 0; mask_tx = 0;
        step(1);
        tx_empty = 1;
        step(1);
        mask_tx = 1; #1;
        check("R6 masked rise ignored", irq_n, 1'b1);
        tx_empty = 0;
        step(1);
    endtask

    task automatic t_tx_collide();
        masks(0, 0, 0, 1);
        tx_empty = 1;
        step(1);
        check("R6 latch set again", irq_n, 1'b0);
        tx_empty = 0;
        step(1);
        check("R7 drop does not clear", irq_n, 1'b0);
        tx_empty = 1; rd_cs_rise = 1;
        step(1);
        rd_cs_rise = 0;
        check("R7 set wins over read", irq_n, 1'b0);
        rd_cs_rise = 1;
        step(1);
        rd_cs_rise = 0;
        check("R7 later read clears", irq_n, 1'b1);
        mask_tx = 0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_parity();
        t_rx_avail();
        t_shutdown_activity();
        t_framing();
        t_tx();
        t_tx_collide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule